// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the timing core of a successive-approximation A/D converter. A start pulse launches a conversion. The block then works through a fixed schedule of sampling, comparison and end phases. During each comparison phase it drives a trial code to the capacitor DAC and reads the comparator's decision. It resolves the most significant bit first, and when the schedule ends it presents the finished code.

The clock runs at twice the conversion-clock rate, so each clock edge is one half-cycle tick. Phases of 2.0, 2.5, 4.0 and 8.0 conversion cycles are therefore counted as 4, 5, 8 and 16 ticks.

Two inputs are captured when the start pulse is accepted:
- The resolution select chooses 8 or 10 bits.
- The hold enable chooses the schedule. With hold off, every bit gets its own sampling phase and the end phase is long. With hold on, only the first bit is sampled and the end phase is short.

The analog comparator, the capacitor array, channel selection and any register access sit outside this block.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `sample`, `dac_code` and `result` are all 0.
- R2: A `start` pulse seen while idle makes `busy` 1 from the next tick. The first bit's sampling phase then lasts 8 ticks, and `sample` is 1 for those 8 ticks.
- R3: With hold off, `done` rises exactly 98 ticks after the accepting edge in 8-bit mode, and exactly 118 ticks after it in 10-bit mode. These are 49 and 59 conversion cycles.
- R4: With hold on, `done` rises exactly 56 ticks after the accepting edge in 8-bit mode, and exactly 66 ticks after it in 10-bit mode. These are 28 and 33 conversion cycles.
- R5: With hold off, each bit after the first has its own 5-tick sampling phase, so `sample` is high for 43 ticks (8-bit) or 53 ticks (10-bit) per conversion. With hold on, `sample` is high for only 8 ticks.
- R6: The result is right-aligned. In 8-bit mode it occupies bits [7:0] and bits [9:8] are 0. Each bit is kept when `cmp_hi` is 1 at the end of its comparison phase. With a comparator that reports input >= trial code, the result equals the input, clipped to 2^N-1.
- R7: `done` is high for exactly one tick. On that same tick `busy` falls and `result` takes the new code. `result` does not change at any other time.
- R8: Changes to `res10` or `hold_en` while busy are ignored. The running conversion keeps the latency and the result of the settings latched at start.
- R9: A `start` pulse while busy is ignored. The running conversion is unaffected and no second conversion follows it.
- R10: When a bit's comparison phase begins, that bit is set to 1 in `dac_code`. For the MSB this happens 8 ticks after the accepting edge, when `dac_code` equals 2^(N-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the conversion-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request pulse |
| res10 | input | 1 | 1 selects 10-bit resolution, 0 selects 8-bit |
| hold_en | input | 1 | 1 selects the sample-and-hold schedule |
| cmp_hi | input | 1 | Comparator decision: analog input >= trial code |
| dac_code | output | 10 | Trial code driven to the DAC |
| sample | output | 1 | High during sampling phases |
| busy | output | 1 | Conversion in progress |
| result | output | 10 | Last completed code, right-aligned |
| done | output | 1 | One-tick pulse marking completion |

## Verification
The bench drives the comparator from a modelled input voltage and runs conversions in all four resolution and hold combinations.

- Inputs of zero, full scale, alternating bit patterns and over-range values separate a correct MSB-first search from misordered or stuck bits.
- Counting start-to-done ticks and sample-high ticks in each combination separates the two schedules and catches phase-length errors of a single tick.
- Conversions with the mode inputs toggled mid-run, or with an extra start pulse, separate latched settings from live ones.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    parameter int MAX_BITS = 10;
    parameter int LOW_BITS = 8;
    parameter int IDX_W    = $clog2(MAX_BITS);
    parameter int CNT_W    = 5;

    // phase lengths in half-cycle ticks
    parameter int T_SAMP_FIRST  = 8;
    parameter int T_SAMP_NEXT   = 5;
    parameter int T_COMP_FIRST  = 4;   // first bit, hold off
    parameter int T_COMP        = 5;
    parameter int T_END_NOHOLD  = 16;
    parameter int T_END_HOLD    = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_COMP = 2'd2,
        PH_END  = 2'd3
    } phase_e;

    typedef struct packed {
        logic wide;
        logic hold;
    } mode_t;

    function automatic logic [CNT_W-1:0] reload(input int ticks);
        return CNT_W'(ticks - 1);
    endfunction

    function automatic logic [IDX_W-1:0] msb_idx(input logic wide);
        return wide ? IDX_W'(MAX_BITS - 1) : IDX_W'(LOW_BITS - 1);
    endfunction

endpackage

// File: rtl/sar_phase_timer.sv
module sar_phase_timer
    import sar_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg
    import sar_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wipe,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                drop_en,
    input  logic [IDX_W-1:0]    drop_idx,
    output logic [MAX_BITS-1:0] code
);
    logic [MAX_BITS-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            code_q <= '0;
        end else begin
            for (int i = 0; i < MAX_BITS; i++) begin
                if (drop_en && drop_idx == IDX_W'(i)) code_q[i] <= 1'b0;
                if (set_en  && set_idx  == IDX_W'(i)) code_q[i] <= 1'b1;
            end
        end
    end

    assign code = code_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                res10,
    input  logic                hold_en,
    input  logic                cmp_hi,
    output logic [MAX_BITS-1:0] dac_code,
    output logic                sample,
    output logic                busy,
    output logic [MAX_BITS-1:0] result,
    output logic                done
);
    phase_e              phase_q, phase_d;
    mode_t               mode_q;
    logic [IDX_W-1:0]    bit_q, bit_d;
    logic                tmr_load, tmr_exp;
    logic [CNT_W-1:0]    tmr_val;
    logic                set_en, drop_en, wipe, finish;
    logic [IDX_W-1:0]    set_idx;
    logic [MAX_BITS-1:0] code;
    logic [MAX_BITS-1:0] result_q;
    logic                done_q;

    sar_phase_timer u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(tmr_exp)
    );

    sar_code_reg u_code (
        .clk(clk), .rst(rst), .wipe(wipe),
        .set_en(set_en), .set_idx(set_idx),
        .drop_en(drop_en), .drop_idx(bit_q),
        .code(code)
    );

    always_comb begin
        phase_d  = phase_q;
        bit_d    = bit_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        set_en   = 1'b0;
        set_idx  = bit_q;
        drop_en  = 1'b0;
        wipe     = 1'b0;
        finish   = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (start) begin
                phase_d  = PH_SAMP;
                bit_d    = msb_idx(res10);
                tmr_load = 1'b1;
                tmr_val  = reload(T_SAMP_FIRST);
                wipe     = 1'b1;
            end
            PH_SAMP: if (tmr_exp) begin
                phase_d  = PH_COMP;
                tmr_load = 1'b1;
                tmr_val  = (bit_q == msb_idx(mode_q.wide) && !mode_q.hold)
                           ? reload(T_COMP_FIRST) : reload(T_COMP);
                set_en   = 1'b1;
            end
            PH_COMP: if (tmr_exp) begin
                drop_en  = !cmp_hi;
                tmr_load = 1'b1;
                if (bit_q == '0) begin
                    phase_d = PH_END;
                    tmr_val = mode_q.hold ? reload(T_END_HOLD) : reload(T_END_NOHOLD);
                end else begin
                    bit_d = bit_q - 1'b1;
                    if (mode_q.hold) begin
                        tmr_val = reload(T_COMP);
                        set_en  = 1'b1;
                        set_idx = bit_q - 1'b1;
                    end else begin
                        phase_d = PH_SAMP;
                        tmr_val = reload(T_SAMP_NEXT);
                    end
                end
            end
            PH_END: if (tmr_exp) begin
                phase_d = PH_IDLE;
                finish  = 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            mode_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            bit_q   <= bit_d;
            done_q  <= finish;
            if (phase_q == PH_IDLE && start) begin
                mode_q.wide <= res10;
                mode_q.hold <= hold_en;
            end
            if (finish)
                result_q <= code;
        end
    end

    assign dac_code = code;
    assign sample   = (phase_q == PH_SAMP);
    assign busy     = (phase_q != PH_IDLE);
    assign result   = result_q;
    assign done     = done_q;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker
    import sar_seq_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                sample,
    input logic                busy,
    input logic                done,
    input logic [MAX_BITS-1:0] result
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_samp_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        sample |-> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !sample);
endmodule

bind sar_seq_top sar_seq_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .sample(sample),
    .busy(busy), .done(done), .result(result)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       res10 = 1'b0;
    logic       hold_en = 1'b0;
    logic       cmp_hi;
    logic [9:0] dac_code, result;
    logic       sample, busy, done;
    int unsigned vin = 0;
    int         n_run = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign cmp_hi = (vin >= 32'(dac_code));

    sar_seq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .res10(res10), .hold_en(hold_en),
        .cmp_hi(cmp_hi), .dac_code(dac_code), .sample(sample), .busy(busy),
        .result(result), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // disturb: 0 none, 1 toggle mode inputs mid-run, 2 extra start mid-run
    task automatic run_conv(input logic wide, input logic hold, input int unsigned v,
                            input int disturb);
        int nb      = wide ? 10 : 8;
        int exp_lat = hold ? (wide ? 66 : 56) : (wide ? 118 : 98);
        int exp_smp = hold ? 8 : 8 + 5 * (nb - 1);
        int unsigned lim = (1 << nb) - 1;
        int unsigned exp_res = (v > lim) ? lim : v;
        int k = 0;
        int smp = 0;
        vin = v;
        @(negedge clk);
        res10 = wide; hold_en = hold; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", int'(busy), 1);
        if (sample) smp++;
        while (!done && k < 400) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (k == 8)
                check("R10 MSB trial code", int'(dac_code), 1 << (nb - 1));
            if (k == 30 && disturb == 1) begin res10 = ~wide; hold_en = ~hold; end
            if (k == 30 && disturb == 2) start = 1'b1;
            if (k == 31) start = 1'b0;
            if (sample) smp++;
        end
        if (hold) check("R4 latency hold on", k, exp_lat);
        else      check("R3 latency hold off", k, exp_lat);
        check("R5 sample ticks", smp, exp_smp);
        check("R6 result", int'(result), int'(exp_res));
        check("R7 busy low with done", int'(busy), 0);
        if (disturb == 1) check("R8 mode change ignored", k, exp_lat);
        @(negedge clk);
        check("R7 done single tick", int'(done), 0);
        res10 = wide; hold_en = hold;
        if (disturb == 2) begin
            repeat (3) @(negedge clk);
            check("R9 no second conversion", int'(busy), 0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy reset", int'(busy), 0);
        check("R1 done reset", int'(done), 0);
        check("R1 sample reset", int'(sample), 0);
        check("R1 dac reset", int'(dac_code), 0);
        check("R1 result reset", int'(result), 0);
        run_conv(1'b0, 1'b0, 8'hA5, 0);
        run_conv(1'b1, 1'b0, 10'h2AA, 0);
        run_conv(1'b0, 1'b1, 0, 0);
        run_conv(1'b1, 1'b1, 10'h3FF, 0);
        run_conv(1'b0, 1'b1, 300, 0);
        run_conv(1'b1, 1'b1, 10'h155, 0);
        run_conv(1'b0, 1'b0, 8'h5A, 1);
        run_conv(1'b1, 1'b1, 10'h123, 1);
        run_conv(1'b1, 1'b0, 10'h201, 2);
        run_conv(1'b0, 1'b1, 8'h81, 2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule